// File: doc/BRIEF.md
# Per-Hart Message-Signalled Interrupt File

This block collects message-signalled interrupts for one hart. Every write that reaches the hart's MSI page carries an interrupt identity as its data, and that write sets the identity's pending bit. Software enables identities one by one, sets a priority threshold and turns delivery on or off. It reaches all of this state through an indirect register pair: it first writes a select register with an index, then reads or writes a 64-bit data register. Identities run from 1 to `NUM_IDS-1`. Identity 0 never exists.

A claim port always shows the most urgent identity that is pending, enabled and allowed by the threshold. The lowest number is the most urgent. Writing the claim port clears that identity's pending bit, so one read followed by one write takes an interrupt. A single level output asks the hart for an external interrupt whenever delivery is on and something can be claimed.

Page decoding across harts and the bus fabric sit outside the block. The MSI write strobe arrives already qualified for this hart.

Top module: `msi_intr_file`

## Requirements
- R1: After reset, all pending and enable bits are 0, delivery is off, the threshold is 0, `ext_irq` is low and `claim_rdata` reads 0.
- R2: An MSI write with data N, where 1 <= N < NUM_IDS, sets pending bit N from the next cycle on. A write with data 0, or with data of NUM_IDS or more, sets no bit.
- R3: `reg_rdata` shows the register named by the select value that was written on an earlier cycle. A data write to that register takes effect on the next cycle.
- R4: Select index 0x70 is the delivery control, and its bit 0 enables delivery. Select index 0x72 is the threshold, held in bits 10:0. Both registers read back the values written to them.
- R5: The pending words sit at index 0x80+2k and the enable words at index 0xC0+2k, for k from 0 to NUM_IDS/64-1. Identity N is bit N mod 64 of word k = N/64. Bit 0 of pending word 0x80 always reads 0, even after a write of ones.
- R6: An odd index, or an index that maps to no register, reads as 0. Writes to such an index change no state.
- R7: `claim_rdata` holds the winning identity in bits 26:16 and zeros in all other bits. The winner is the lowest identity that is pending, enabled and eligible. When there is no winner, `claim_rdata` is 0.
- R8: With a threshold T of 0, every identity is eligible. With a non-zero T, only identities below T are eligible.
- R9: `ext_irq` is high exactly when delivery is enabled and a winner exists.
- R10: A claim write clears the pending bit of the current winner, whatever else is happening. When no winner exists, a claim write changes nothing.
- R11: When a claim write and an MSI write for the winner's identity arrive in the same cycle, that pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_we | input | 1 | MSI write to this hart's page |
| msi_data | input | 32 | MSI data, which is the interrupt identity |
| sel_we | input | 1 | Write strobe for the select register |
| sel_data | input | 12 | New select index |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 64 | Data for the selected register |
| reg_rdata | output | 64 | Contents of the selected register |
| claim_we | input | 1 | Claim write, which clears the winner's pending bit |
| claim_rdata | output | 32 | Winning identity in bits 26:16 |
| ext_irq | output | 1 | External interrupt request to the hart |

## Verification
The assertions assume that every strobe is a clean 0 or 1 after reset. They also assume that software changes the select value on one cycle and uses the data register on a later cycle. The stimulus keeps to both rules: each select write has a cycle to itself before any data access, and strobes are driven only on the falling edge. The one deliberate overlap is a claim write together with an MSI write for the same identity, which exercises the set-wins rule. No other access overlaps a claim, so the assertion that a claim clears the winner's bit holds wherever it applies.

// File: rtl/msi_file_pkg.sv
`timescale 1ns/1ps
package msi_file_pkg;
    localparam int ID_W        = 11;   // identity field width in the claim word
    localparam int SEL_W       = 12;   // indirect select index width
    localparam int WORD_W      = 64;   // indirect data register width
    localparam int CLAIM_SHIFT = 16;   // identity position in the claim word

    localparam logic [SEL_W-1:0] IDX_DELIV     = 12'h070;
    localparam logic [SEL_W-1:0] IDX_THRESH    = 12'h072;
    localparam logic [SEL_W-1:0] IDX_PEND_BASE = 12'h080;
    localparam logic [SEL_W-1:0] IDX_ENAB_BASE = 12'h0C0;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_DELIV,
        TGT_THRESH,
        TGT_PEND,
        TGT_ENAB
    } reg_tgt_e;
endpackage

// File: rtl/msi_sel_decode.sv
`timescale 1ns/1ps
module msi_sel_decode
    import msi_file_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    localparam int WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic [SEL_W-1:0]  sel,
    output reg_tgt_e          tgt,
    output logic [WIDX_W-1:0] word_idx
);
    logic [SEL_W-1:0] pend_off;
    logic [SEL_W-1:0] enab_off;
    logic             pend_hit;
    logic             enab_hit;

    always_comb begin
        pend_off = sel - IDX_PEND_BASE;
        enab_off = sel - IDX_ENAB_BASE;
        pend_hit = (sel >= IDX_PEND_BASE) && (pend_off < SEL_W'(2 * NUM_WORDS)) && !pend_off[0];
        enab_hit = (sel >= IDX_ENAB_BASE) && (enab_off < SEL_W'(2 * NUM_WORDS)) && !enab_off[0];
        tgt      = TGT_NONE;
        word_idx = '0;
        if (sel == IDX_DELIV) begin
            tgt = TGT_DELIV;
        end else if (sel == IDX_THRESH) begin
            tgt = TGT_THRESH;
        end else if (pend_hit) begin
            tgt      = TGT_PEND;
            word_idx = WIDX_W'(pend_off >> 1);
        end else if (enab_hit) begin
            tgt      = TGT_ENAB;
            word_idx = WIDX_W'(enab_off >> 1);
        end
    end
endmodule

// File: rtl/msi_prio_pick.sv
`timescale 1ns/1ps
module msi_prio_pick #(
    parameter int N     = 256,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    // Lowest set bit wins: scan from the top so lower bits overwrite.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/msi_intr_file.sv
`timescale 1ns/1ps
module msi_intr_file
    import msi_file_pkg::*;
#(
    parameter int NUM_IDS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        msi_we,
    input  logic [31:0] msi_data,
    input  logic        sel_we,
    input  logic [11:0] sel_data,
    input  logic        reg_we,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    input  logic        claim_we,
    output logic [31:0] claim_rdata,
    output logic        ext_irq
);
    localparam int NUM_WORDS = NUM_IDS / WORD_W;
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int IDX_W     = $clog2(NUM_IDS);
    localparam int PAD_W     = 32 - ID_W - CLAIM_SHIFT;

    typedef struct packed {
        logic [NUM_IDS-1:0] pend;
        logic [NUM_IDS-1:0] enab;
        logic               deliv;
        logic [ID_W-1:0]    thr;
        logic [SEL_W-1:0]   sel;
    } state_t;

    state_t st_d, st_q;

    reg_tgt_e           tgt;
    logic [WIDX_W-1:0]  word_idx;
    logic [NUM_IDS-1:0] elig;
    logic [NUM_IDS-1:0] cand;
    logic [IDX_W-1:0]   top_idx;
    logic               top_found;
    logic               msi_valid;
    logic [IDX_W-1:0]   msi_idx;
    logic [ID_W-1:0]    top_id;

    msi_sel_decode #(.NUM_WORDS(NUM_WORDS)) u_decode (
        .sel      (st_q.sel),
        .tgt      (tgt),
        .word_idx (word_idx)
    );

    msi_prio_pick #(.N(NUM_IDS)) u_pick (
        .req   (cand),
        .idx   (top_idx),
        .found (top_found)
    );

    always_comb begin
        for (int i = 0; i < NUM_IDS; i++) begin
            elig[i] = (st_q.thr == '0) || (i < int'(st_q.thr));
        end
        cand      = st_q.pend & st_q.enab & elig;
        msi_valid = msi_we && (msi_data != 32'd0) && (msi_data < 32'(NUM_IDS));
        msi_idx   = msi_data[IDX_W-1:0];
        top_id    = top_found ? ID_W'(top_idx) : '0;
    end

    always_comb begin
        claim_rdata = {{PAD_W{1'b0}}, top_id, {CLAIM_SHIFT{1'b0}}};
        ext_irq     = st_q.deliv && top_found;
        unique case (tgt)
            TGT_DELIV:  reg_rdata = {{(WORD_W-1){1'b0}}, st_q.deliv};
            TGT_THRESH: reg_rdata = {{(WORD_W-ID_W){1'b0}}, st_q.thr};
            TGT_PEND:   reg_rdata = st_q.pend[int'(word_idx)*WORD_W +: WORD_W];
            TGT_ENAB:   reg_rdata = st_q.enab[int'(word_idx)*WORD_W +: WORD_W];
            default:    reg_rdata = '0;
        endcase
    end

    // Next state: register write, then claim clear, then MSI set (set wins).
    always_comb begin
        st_d = st_q;
        if (sel_we) begin
            st_d.sel = sel_data;
        end
        if (reg_we) begin
            unique case (tgt)
                TGT_DELIV:  st_d.deliv = reg_wdata[0];
                TGT_THRESH: st_d.thr   = reg_wdata[ID_W-1:0];
                TGT_PEND:   st_d.pend[int'(word_idx)*WORD_W +: WORD_W] = reg_wdata;
                TGT_ENAB:   st_d.enab[int'(word_idx)*WORD_W +: WORD_W] = reg_wdata;
                default:    ;
            endcase
        end
        if (claim_we && top_found) begin
            st_d.pend[top_idx] = 1'b0;
        end
        if (msi_valid) begin
            st_d.pend[msi_idx] = 1'b1;
        end
        st_d.pend[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_msi_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid |=> st_q.pend[$past(msi_idx)]);

    assert_no_identity_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pend[0]);

    assert_odd_index_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sel[0] |-> (reg_rdata == '0));

    assert_winner_pending_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        top_found |-> (st_q.pend[top_idx] && st_q.enab[top_idx]));

    assert_winner_below_threshold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (top_found && st_q.thr != '0) |-> (ID_W'(top_idx) < st_q.thr));

    assert_irq_needs_delivery_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |-> st_q.deliv);

    assert_claim_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_we && top_found && !msi_we && !reg_we) |=> !st_q.pend[$past(top_idx)]);

    assert_set_beats_claim_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_we && top_found && msi_valid && msi_idx == top_idx) |=> st_q.pend[$past(top_idx)]);
endmodule

// File: tb/msi_intr_file_tb.sv
`timescale 1ns/1ps
module msi_intr_file_tb;
    localparam int NUM_IDS = 256;
    localparam int K_CLAIM = 0;
    localparam int K_IRQ   = 1;
    localparam int K_RDATA = 2;

    typedef struct {
        int          kind;
        logic [63:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_we = 1'b0;
    logic [31:0] msi_data = '0;
    logic        sel_we = 1'b0;
    logic [11:0] sel_data = '0;
    logic        reg_we = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        claim_we = 1'b0;
    logic [31:0] claim_rdata;
    logic        ext_irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    msi_intr_file #(.NUM_IDS(NUM_IDS)) u_dut (
        .clk(clk), .rst_n(rst_n), .msi_we(msi_we), .msi_data(msi_data),
        .sel_we(sel_we), .sel_data(sel_data), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .claim_we(claim_we),
        .claim_rdata(claim_rdata), .ext_irq(ext_irq)
    );

    task automatic push(int kind, logic [63:0] exp, string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic exp_claim(int id, string req);
        push(K_CLAIM, 64'(id) << 16, req);
    endtask

    task automatic exp_irq(bit v, string req);
        push(K_IRQ, 64'(v), req);
    endtask

    // Monitor: compares queued expectations 1 ns after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_CLAIM: act = {32'd0, claim_rdata};
                    K_IRQ:   act = {63'd0, ext_irq};
                    default: act = reg_rdata;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic send_msi(int id);
        @(negedge clk); msi_we = 1'b1; msi_data = 32'(id);
        @(negedge clk); msi_we = 1'b0;
    endtask

    task automatic set_sel(logic [11:0] idx);
        @(negedge clk); sel_we = 1'b1; sel_data = idx;
        @(negedge clk); sel_we = 1'b0;
    endtask

    task automatic wr_reg(logic [11:0] idx, logic [63:0] d);
        set_sel(idx);
        reg_we = 1'b1; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd_reg(logic [11:0] idx, logic [63:0] exp, string req);
        set_sel(idx);
        push(K_RDATA, exp, req);
    endtask

    task automatic do_claim();
        @(negedge clk); claim_we = 1'b1;
        @(negedge clk); claim_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        exp_claim(0, "R1 claim after reset");
        exp_irq(0, "R1 irq after reset");
        rd_reg(12'h070, 64'd0, "R1 delivery after reset");
        rd_reg(12'h072, 64'd0, "R1 threshold after reset");
        rd_reg(12'h080, 64'd0, "R1 pending after reset");

        // R5 enable layout: identities 5, 70, 200
        wr_reg(12'h0C0, 64'h1 << 5);
        wr_reg(12'h0C2, 64'h1 << 6);
        wr_reg(12'h0C6, 64'h1 << 8);
        rd_reg(12'h0C2, 64'h1 << 6, "R5 enable word 0xC2 readback");

        // R2 MSI sets pending; R7 claim; R9 no delivery yet
        send_msi(70);
        exp_claim(70, "R2 R7 claim after MSI 70");
        exp_irq(0, "R9 irq low while delivery off");
        rd_reg(12'h082, 64'h1 << 6, "R5 pending word 0x82 holds 70");

        // R4 delivery on, R9
        wr_reg(12'h070, 64'd1);
        exp_irq(1, "R9 irq high with delivery on");
        rd_reg(12'h070, 64'd1, "R4 delivery readback");

        // R7 lowest wins
        send_msi(200);
        send_msi(5);
        exp_claim(5, "R7 lowest identity wins");

        // R2 identity 0 and out-of-range ignored
        send_msi(0);
        send_msi(300);
        rd_reg(12'h080, 64'h1 << 5, "R2 MSI 0 sets nothing");
        rd_reg(12'h086, 64'h1 << 8, "R2 MSI 300 sets nothing");

        // R7 pending but disabled identity is not a winner
        send_msi(9);
        exp_claim(5, "R7 disabled identity 9 skipped");
        rd_reg(12'h080, (64'h1 << 5) | (64'h1 << 9), "R5 pending word 0x80");

        // R8 threshold, R3 readback
        wr_reg(12'h072, 64'd6);
        exp_claim(5, "R8 threshold 6 allows 5");
        rd_reg(12'h072, 64'd6, "R3 R4 threshold readback");
        wr_reg(12'h072, 64'd5);
        exp_claim(0, "R8 threshold 5 blocks 5");
        exp_irq(0, "R9 irq low when nothing eligible");
        wr_reg(12'h072, 64'd0);
        exp_claim(5, "R8 threshold 0 allows all");
        exp_irq(1, "R9 irq back high");

        // R6 odd and unmapped indices
        wr_reg(12'h081, '1);
        rd_reg(12'h081, 64'd0, "R6 odd index reads zero");
        rd_reg(12'h080, (64'h1 << 5) | (64'h1 << 9), "R6 odd write left pending");
        wr_reg(12'h0C1, '1);
        rd_reg(12'h0C0, 64'h1 << 5, "R6 odd write left enables");
        wr_reg(12'h088, '1);
        rd_reg(12'h088, 64'd0, "R6 unmapped index reads zero");
        rd_reg(12'h071, 64'd0, "R6 index 0x71 reads zero");
        exp_claim(5, "R6 claim unchanged after ignored writes");

        // R10 claim clears winner
        do_claim();
        exp_claim(70, "R10 claim cleared 5");
        rd_reg(12'h080, 64'h1 << 9, "R10 pending word after claim");

        // R11 set wins over claim clear
        @(negedge clk); claim_we = 1'b1; msi_we = 1'b1; msi_data = 32'd70;
        @(negedge clk); claim_we = 1'b0; msi_we = 1'b0;
        exp_claim(70, "R11 set beats claim");

        do_claim();
        exp_claim(200, "R10 claim cleared 70");
        do_claim();
        exp_claim(0, "R10 claim cleared 200");
        exp_irq(0, "R9 irq low after last claim");
        do_claim();
        rd_reg(12'h080, 64'h1 << 9, "R10 empty claim changes nothing");
        rd_reg(12'h082, 64'd0, "R10 empty claim word 0x82");

        // R5 bit 0 never set
        wr_reg(12'h080, '1);
        rd_reg(12'h080, 64'hFFFF_FFFF_FFFF_FFFE, "R5 identity 0 bit stays clear");
        exp_claim(5, "R7 winner after pending write");

        // R9 delivery off masks irq but not claim
        wr_reg(12'h070, 64'd0);
        exp_irq(0, "R9 irq low with delivery off");
        exp_claim(5, "R7 claim independent of delivery");

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule